// File: doc/BRIEF.md
# CCD Exposure Setting Interface

This block turns the shutter configuration of a CCD camera timing generator into an exposure length. A select pin picks how the configuration arrives. With the select low, two mode pins and a three-bit code pick a preset setting. With the select high, the three code pins become a serial port (strobe, clock, data) that loads a 12-bit word. The word carries its own mode bits, and these take the place of the mode pins.

The block keeps the active shutter mode and a 9-bit load value. From them it produces a registered exposure length, either in lines (high-speed shutter) or in fields (low-speed shutter). The downstream pulse generator reads these outputs as level-held configuration. No data streams through the block, so all pins are plain control and status levels with no valid/ready handshake and no back-pressure. The serial pins are synchronised to the system clock and edge-detected inside the block, so each serial phase must last several system clocks.

Top module: `exposure_setup_if`

## Requirements
- R1: After reset the mode output is off (2'b11) and the line and field counts are 0. In serial mode the active register stays off until the first strobe.
- R2: With `sel_serial` low, `act_mode` equals `mode_pin` one clock after the pins settle. The mode encoding is 00 flickerless, 01 high-speed, 10 low-speed, 11 off.
- R3: In parallel high-speed mode, `code_in` values 0 to 7 select loads 0x196, 0x176, 0x137, 0x118, 0x108, 0x100, 0x0FC and 0x0FA. The matching line counts are 157, 125, 62, 31, 15, 7, 3 and 1.
- R4: In parallel low-speed mode, code k selects load 0x1FE − k and a field count of 2·(k+1).
- R5: In high-speed mode, `line_count` = L − 249 for a load L above 249, and 0 otherwise. `field_count` is 0.
- R6: In low-speed mode, `field_count` = 2·(0x1FF − L), so L = 0x100 gives 510 and L = 0x1FF gives 0. `line_count` is 0.
- R7: Serial bits are sampled on rising edges of `code_in[1]` from `code_in[2]`. The first bit is mode bit 1 (the MSB of the mode), then mode bit 0, then one ignored bit, then load bits D0 to D8.
- R8: A rising edge of `code_in[0]` in serial mode copies the last 12 shifted bits to the active register. Clock edges without a strobe leave the outputs unchanged.
- R9: In serial mode the mode bits from the word are used and `mode_pin` has no effect.
- R10: In flickerless and off modes, both the line count and the field count are 0.
- R11: The serially loaded setting is kept while the block is in parallel mode. It is used again when `sel_serial` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_serial | input | 1 | 0: parallel pins, 1: serial port |
| code_in | input | 3 | Parallel speed code; in serial mode bit0 strobe, bit1 clock, bit2 data |
| mode_pin | input | 2 | Parallel shutter mode (ignored in serial mode) |
| act_mode | output | 2 | Active shutter mode |
| act_load | output | 9 | Active 9-bit load value |
| line_count | output | 9 | Exposure in lines, high-speed mode only |
| field_count | output | 10 | Exposure in fields, low-speed mode only |

## Verification
Assertions check the following on every cycle:
- the line and field counts are never both active, and each is non-zero only in its own mode;
- the field count is always even and the line count never exceeds 262;
- every serial clock edge shifts in the synchronised data bit;
- the active serial register changes only on a strobe edge.

Only the bench scenarios can show the rest:
- the preset tables and the arithmetic at the ends of the load range;
- the bit order of the serial word;
- the mode bits of the word overriding the mode pins;
- the serial setting surviving a detour through parallel mode.

// File: rtl/shut_pkg.sv
package shut_pkg;
  typedef enum logic [1:0] {
    SM_FLICKERLESS = 2'b00,
    SM_HIGH        = 2'b01,
    SM_LOW         = 2'b10,
    SM_OFF         = 2'b11
  } smode_t;

  localparam int LOAD_W  = 9;
  localparam int WORD_W  = 12;
  localparam int LINE_W  = 9;
  localparam int FIELD_W = 10;
  localparam int CODE_W  = 3;
  localparam int LINE_BASE = 249;
  localparam logic [LOAD_W-1:0] LOAD_MAX = '1;
endpackage

// File: rtl/ser_word_rx.sv
module ser_word_rx
  import shut_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic              sck_i,
  input  logic              sdat_i,
  output smode_t            mode_o,
  output logic [LOAD_W-1:0] load_o
);
  localparam int MODE_HI = WORD_W - 1;
  localparam int MODE_LO = WORD_W - 2;

  logic [2:0] sync_q [SYNC_STAGES];
  logic [2:0] prev_q;
  logic [WORD_W-1:0] shift_q;
  logic stb_s, sck_s, dat_s, stb_rise, sck_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= {stb_i, sck_i, sdat_i};

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[g] <= '0;
      else        sync_q[g] <= sync_q[g-1];
  end

  assign {stb_s, sck_s, dat_s} = sync_q[SYNC_STAGES-1];
  assign stb_rise = stb_s & ~prev_q[2];
  assign sck_rise = sck_s & ~prev_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q  <= '0;
      shift_q <= '0;
      mode_o  <= SM_OFF;
      load_o  <= LOAD_MAX;
    end else begin
      prev_q <= {stb_s, sck_s, dat_s};
      if (sck_rise) shift_q <= {shift_q[WORD_W-2:0], dat_s};
      if (stb_rise) begin
        mode_o <= smode_t'({shift_q[MODE_HI], shift_q[MODE_LO]});
        for (int i = 0; i < LOAD_W; i++) load_o[i] <= shift_q[LOAD_W-1-i];
      end
    end

  AST_SHIFT_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> shift_q[0] == $past(dat_s));                       // R7
  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(mode_o) && $stable(load_o));              // R8
endmodule

// File: rtl/par_decode.sv
module par_decode
  import shut_pkg::*;
(
  input  smode_t            mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LOAD_W-1:0] load_o
);
  always_comb begin
    if (mode_i == SM_LOW) begin
      load_o = LOAD_MAX - LOAD_W'(code_i) - LOAD_W'(1);
    end else begin
      unique case (code_i)
        3'd0: load_o = 9'h196;
        3'd1: load_o = 9'h176;
        3'd2: load_o = 9'h137;
        3'd3: load_o = 9'h118;
        3'd4: load_o = 9'h108;
        3'd5: load_o = 9'h100;
        3'd6: load_o = 9'h0FC;
        default: load_o = 9'h0FA;
      endcase
    end
  end
endmodule

// File: rtl/exp_calc.sv
module exp_calc
  import shut_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  smode_t             mode_i,
  input  logic [LOAD_W-1:0]  load_i,
  output smode_t             mode_o,
  output logic [LOAD_W-1:0]  load_o,
  output logic [LINE_W-1:0]  lines_o,
  output logic [FIELD_W-1:0] fields_o
);
  localparam logic [LOAD_W-1:0] BASE = LOAD_W'(LINE_BASE);

  logic [LINE_W-1:0]  lines_d;
  logic [FIELD_W-1:0] fields_d;

  always_comb begin
    lines_d  = '0;
    fields_d = '0;
    if (mode_i == SM_HIGH && load_i > BASE)
      lines_d = LINE_W'(load_i - BASE);
    if (mode_i == SM_LOW)
      fields_d = {LOAD_MAX - load_i, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_o   <= SM_OFF;
      load_o   <= LOAD_MAX;
      lines_o  <= '0;
      fields_o <= '0;
    end else begin
      mode_o   <= mode_i;
      load_o   <= load_i;
      lines_o  <= lines_d;
      fields_o <= fields_d;
    end

  AST_LINES_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lines_o != '0 |-> mode_o == SM_HIGH);                           // R5
  AST_FIELDS_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fields_o != '0 |-> mode_o == SM_LOW);                           // R6
  AST_FIELDS_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    fields_o[0] == 1'b0);                                           // R6
  AST_LINES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lines_o <= LINE_W'(262));                                       // R5
  AST_QUIET_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == SM_OFF || mode_o == SM_FLICKERLESS) |-> lines_o == '0 && fields_o == '0); // R10
endmodule

// File: rtl/exposure_setup_if.sv
module exposure_setup_if
  import shut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_serial,
  input  logic [2:0]  code_in,
  input  logic [1:0]  mode_pin,
  output logic [1:0]  act_mode,
  output logic [8:0]  act_load,
  output logic [8:0]  line_count,
  output logic [9:0]  field_count
);
  smode_t            ser_mode, par_mode, sel_mode, out_mode;
  logic [LOAD_W-1:0] ser_load, par_load, sel_load;

  assign par_mode = smode_t'(mode_pin);

  ser_word_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .stb_i(sel_serial & code_in[0]),
    .sck_i(sel_serial & code_in[1]),
    .sdat_i(code_in[2]),
    .mode_o(ser_mode), .load_o(ser_load)
  );

  par_decode u_dec (.mode_i(par_mode), .code_i(code_in), .load_o(par_load));

  assign sel_mode = sel_serial ? ser_mode : par_mode;
  assign sel_load = sel_serial ? ser_load : par_load;

  exp_calc u_calc (
    .clk(clk), .rst_n(rst_n),
    .mode_i(sel_mode), .load_i(sel_load),
    .mode_o(out_mode), .load_o(act_load),
    .lines_o(line_count), .fields_o(field_count)
  );

  assign act_mode = out_mode;

  AST_PARALLEL_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_serial && $stable(mode_pin) && $stable(sel_serial)) |=> act_mode == $past(mode_pin)); // R2
endmodule

// File: tb/exposure_setup_if_bench.sv
module exposure_setup_if_bench;
  logic clk = 0, rst_n = 0, sel_serial = 0;
  logic [2:0] code_in = 0;
  logic [1:0] mode_pin = 2'b11;
  logic [1:0] act_mode;
  logic [8:0] act_load, line_count;
  logic [9:0] field_count;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exposure_setup_if u_exposure_setup_if (.*);

  // {mode, code, load, lines, fields}
  localparam logic [32:0] VEC [0:17] = '{
    {2'b01,3'd0,9'h196,9'd157,10'd0}, {2'b01,3'd1,9'h176,9'd125,10'd0},
    {2'b01,3'd2,9'h137,9'd62,10'd0},  {2'b01,3'd3,9'h118,9'd31,10'd0},
    {2'b01,3'd4,9'h108,9'd15,10'd0},  {2'b01,3'd5,9'h100,9'd7,10'd0},
    {2'b01,3'd6,9'h0FC,9'd3,10'd0},   {2'b01,3'd7,9'h0FA,9'd1,10'd0},
    {2'b10,3'd0,9'h1FE,9'd0,10'd2},   {2'b10,3'd1,9'h1FD,9'd0,10'd4},
    {2'b10,3'd2,9'h1FC,9'd0,10'd6},   {2'b10,3'd3,9'h1FB,9'd0,10'd8},
    {2'b10,3'd4,9'h1FA,9'd0,10'd10},  {2'b10,3'd5,9'h1F9,9'd0,10'd12},
    {2'b10,3'd6,9'h1F8,9'd0,10'd14},  {2'b10,3'd7,9'h1F7,9'd0,10'd16},
    {2'b00,3'd2,9'h137,9'd0,10'd0},   {2'b11,3'd5,9'h100,9'd0,10'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int m, input int l,
                            input int ln, input int fd);
    check(req, act_mode, m);
    check(req, act_load, l);
    check(req, line_count, ln);
    check(req, field_count, fd);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [1:0] m, input logic [8:0] ld);
    logic [11:0] w;
    w = {m[1], m[0], 1'b0, ld[0], ld[1], ld[2], ld[3], ld[4], ld[5], ld[6], ld[7], ld[8]};
    for (int i = 11; i >= 0; i--) begin
      code_in[2] = w[i]; wait_clk(3);
      code_in[1] = 1'b1; wait_clk(3);
      code_in[1] = 1'b0; wait_clk(3);
    end
  endtask

  task automatic send_word(input logic [1:0] m, input logic [8:0] ld);
    shift_bits(m, ld);
    code_in[0] = 1'b1; wait_clk(4);
    code_in[0] = 1'b0; wait_clk(8);
  endtask

  initial begin
    wait_clk(3);
    expect_out("R1 reset", 3, 511, 0, 0);
    rst_n = 1;
    wait_clk(2);
    sel_serial = 1; mode_pin = 2'b01; wait_clk(4);
    expect_out("R1 serial before strobe", 3, 511, 0, 0);
    sel_serial = 0;

    for (int v = 0; v < 18; v++) begin
      mode_pin = VEC[v][32:31]; code_in = VEC[v][30:28];
      wait_clk(2);
      check("R2 mode", act_mode, VEC[v][32:31]);
      check(VEC[v][32:31] == 2'b01 ? "R3 load" : "R4 load", act_load, VEC[v][27:19]);
      check(VEC[v][32:31] == 2'b01 ? "R3 lines" : "R10 lines", line_count, VEC[v][18:10]);
      check(VEC[v][32:31] == 2'b10 ? "R4 fields" : "R10 fields", field_count, VEC[v][9:0]);
    end

    code_in = 0; mode_pin = 2'b00; sel_serial = 1; wait_clk(4);
    send_word(2'b01, 9'h1FF);
    expect_out("R5 top load", 1, 511, 262, 0);
    send_word(2'b01, 9'h0F0);
    expect_out("R5 below base", 1, 9'h0F0, 0, 0);
    send_word(2'b10, 9'h100);
    expect_out("R6 longest", 2, 256, 0, 510);
    send_word(2'b10, 9'h1FF);
    expect_out("R6 zero", 2, 511, 0, 0);
    send_word(2'b01, 9'h12D);
    expect_out("R7 bit order", 1, 9'h12D, 9'h12D - 249, 0);
    mode_pin = 2'b01;
    send_word(2'b10, 9'h1F0);
    expect_out("R9 override", 2, 9'h1F0, 0, 30);
    shift_bits(2'b01, 9'h0FA); wait_clk(8);
    expect_out("R8 no strobe", 2, 9'h1F0, 0, 30);
    send_word(2'b00, 9'h196);
    expect_out("R10 flickerless", 0, 9'h196, 0, 0);
    send_word(2'b10, 9'h1E0);
    sel_serial = 0; code_in = 3'd3; mode_pin = 2'b01; wait_clk(2);
    expect_out("R11 parallel detour", 1, 9'h118, 31, 0);
    code_in = 0; sel_serial = 1; wait_clk(2);
    expect_out("R11 serial kept", 2, 9'h1E0, 0, 62);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule